// File: doc/BRIEF.md
# Multi-Channel Timer Control Core

This block is the control and status core of a multi-channel timer. It chooses where count pulses come from: the system clock passed through a power-of-two prescaler, the system clock gated by the level of an external timer pin, or single edges on that pin with the prescaler bypassed. It then drives a counter that either runs up to a reload value and wraps, or runs up to the reload value and back down to zero. Each finished count cycle is flagged.

A status byte reports whether a count cycle has finished and whether any capture/compare channel has raised its event flag. It also holds the interrupt enable and the clock source field. The cycle flag is cleared by writing a one to it, and it is held at zero while the timer is off. A prescaler value written while the timer runs is kept in a shadow register and only takes over at the next cycle end. A one-cycle interrupt pulse marks each cycle end when interrupts are enabled.

Software reaches the block through a byte-wide register port with four addresses. The channel logic, the pin drivers and the interrupt controller are separate blocks.

Top module: `mtc_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `count` is 0 and `cnt_irq` is low.
- R2: Address 0 is the status byte: bit 7 cycle-done (write 1 clears), bit 6 channel status (read-only), bit 5 interrupt enable, bits 4 and 3 always read 0, bits 2..0 clock source. Address 1 is the setup byte: bit 7 timer enable, bit 6 mode (0 wrap, 1 up/down), bits 2..0 prescale exponent P. Address 2 is the reload high byte and address 3 the reload low byte. Reads are combinational.
- R3: Source 000 advances the counter once per 2^P system cycles in which `sclk_en` is high, measured from the enabling write. The prescaler is held at zero while the timer is off.
- R4: Source 010 counts system cycles while the synchronized pin is high, and source 011 counts them while it is low. The pin passes through two flip-flops, so a change on the pin first gates the count edge two edges later.
- R5: Source 100 adds exactly one count per rising pin edge and source 101 one per falling pin edge, whatever the value of P.
- R6: Sources 001, 110 and 111 stop the counter and leave all other state unchanged.
- R7: In wrap mode the count starts at 0 after enable and steps by one. A tick taken while the count equals the reload value loads 1 and completes a cycle. The reload value is assumed to be at least 2.
- R8: In up/down mode the count rises from 0 to the reload value, then falls. The tick that brings it to 0 completes a cycle and turns it upward again.
- R9: A prescale write while the timer is enabled leaves the active divider unchanged until the next cycle completion. A prescale write while the timer is off takes effect at once. Address 1 reads back the last written value.
- R10: The cycle-done bit sets on a completion and clears when a 1 is written to it; a completion in the same cycle wins. It reads 0 while the timer is off.
- R11: The channel status bit equals the OR of the per-channel event inputs while the timer is enabled, and reads 0 otherwise.
- R12: `cnt_irq` is high for exactly the one cycle after each completing tick when the interrupt enable is 1. It never pulses when the enable is 0.
- R13: Turning the timer off brings `count` to 0 on the next edge and resets the direction to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_en | input | 1 | System clock qualifier for sources 000/010/011 |
| tmr_in | input | 1 | Asynchronous timer input pin |
| ch_evt | input | NCH | Per-channel capture/compare event flags |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| count | output | CNT_W | Current counter value |
| cnt_irq | output | 1 | Count-cycle interrupt pulse |

## Verification
Random runs on the free-running system source use different reload values, prescale exponents, modes and run lengths. Comparing the final count and the number of interrupt pulses against closed-form functions tells wrap behaviour apart from up/down reflection and exposes off-by-one errors in the divider. Directed pin patterns separate the two gated polarities and the two edge polarities, and they show the two-cycle synchronizer delay. A prescale change made mid-cycle shows whether the divider switches at the cycle end or too early. Reserved sources and a low `sclk_en` show whether the count really freezes.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
   typedef enum logic [2:0] {
      SRC_SYS  = 3'b000,
      SRC_RSV1 = 3'b001,
      SRC_GHI  = 3'b010,
      SRC_GLO  = 3'b011,
      SRC_RISE = 3'b100,
      SRC_FALL = 3'b101,
      SRC_RSV6 = 3'b110,
      SRC_RSV7 = 3'b111
   } clk_src_e;

   typedef enum logic {
      MODE_WRAP = 1'b0,
      MODE_UPDN = 1'b1
   } cnt_mode_e;

   localparam logic [1:0] A_STAT  = 2'd0;
   localparam logic [1:0] A_SETUP = 2'd1;
   localparam logic [1:0] A_RLDH  = 2'd2;
   localparam logic [1:0] A_RLDL  = 2'd3;
endpackage

// File: rtl/mtc_insync.sv
module mtc_insync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-1:0], pin_i};
   end

   assign level_o = sh_q[STAGES-1];
   assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall_o  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/mtc_tick.sv
module mtc_tick
   import mtc_pkg::*;
#(
   parameter int unsigned PRES_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  clk_src_e          src_i,
   input  logic              sclk_en_i,
   input  logic              level_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic [PRES_W-1:0] pres_i,
   output logic              tick_o
);
   localparam int unsigned PCW = (1 << PRES_W) - 1;

   logic [PCW-1:0] pcnt_q, lim;
   logic pre_tick, direct, use_direct;

   always_comb begin
      pre_tick   = 1'b0;
      direct     = 1'b0;
      use_direct = 1'b0;
      unique case (src_i)
         SRC_SYS:  pre_tick = sclk_en_i;
         SRC_GHI:  pre_tick = sclk_en_i & level_i;
         SRC_GLO:  pre_tick = sclk_en_i & ~level_i;
         SRC_RISE: begin use_direct = 1'b1; direct = rise_i; end
         SRC_FALL: begin use_direct = 1'b1; direct = fall_i; end
         default:  ;
      endcase
   end

   assign lim = PCW'((32'd1 << pres_i) - 32'd1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                pcnt_q <= '0;
      else if (!en_i)             pcnt_q <= '0;
      else if (pre_tick) begin
         if (pcnt_q == lim)       pcnt_q <= '0;
         else                     pcnt_q <= pcnt_q + 1'b1;
      end
   end

   assign tick_o = en_i & (use_direct ? direct : (pre_tick && (pcnt_q == lim)));

   AST_RESV_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_i inside {SRC_RSV1, SRC_RSV6, SRC_RSV7}) |-> !tick_o)
      else $error("reserved source produced a tick"); // R6
endmodule

// File: rtl/mtc_counter.sv
module mtc_counter
   import mtc_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  cnt_mode_e        mode_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             done_o
);
   logic [CNT_W-1:0] cnt_q, nxt;
   logic up_q, nup;

   always_comb begin
      nxt    = cnt_q;
      nup    = up_q;
      done_o = 1'b0;
      if (tick_i) begin
         if (mode_i == MODE_WRAP) begin
            nup = 1'b1;
            if (cnt_q == reload_i) begin
               nxt    = CNT_W'(1);
               done_o = 1'b1;
            end else begin
               nxt = cnt_q + 1'b1;
            end
         end else if (up_q) begin
            if (cnt_q >= reload_i) begin
               nxt = cnt_q - 1'b1;
               nup = 1'b0;
            end else begin
               nxt = cnt_q + 1'b1;
            end
         end else if (cnt_q <= CNT_W'(1)) begin
            nxt    = '0;
            nup    = 1'b1;
            done_o = 1'b1;
         end else begin
            nxt = cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else if (!en_i) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else begin
         cnt_q <= nxt;
         up_q  <= nup;
      end
   end

   assign cnt_o = cnt_q;

   AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !tick_i) |=> $stable(cnt_q))
      else $error("count moved without a tick"); // R3
   AST_DIS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (cnt_q == '0))
      else $error("count not cleared while disabled"); // R13
endmodule

// File: rtl/mtc_ctrl.sv
module mtc_ctrl
   import mtc_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned PRES_W      = 3,
   parameter int unsigned NCH         = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_en,
   input  logic             tmr_in,
   input  logic [NCH-1:0]   ch_evt,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic [CNT_W-1:0] count,
   output logic             cnt_irq
);
   localparam int unsigned HI_W = CNT_W - 8;

   initial begin
      assert (CNT_W >= 9 && CNT_W <= 16) else $fatal(1, "CNT_W out of range");
      assert (PRES_W >= 1 && PRES_W <= 3) else $fatal(1, "PRES_W out of range");
      assert (NCH >= 1) else $fatal(1, "NCH must be positive");
      assert (SYNC_STAGES >= 2) else $fatal(1, "SYNC_STAGES below 2");
   end

   logic             cyc_st_q, ie_q, en_q, irq_q, en_d, done, tick;
   logic             wr_stat, wr_setup, ch_st;
   clk_src_e         src_q;
   cnt_mode_e        mode_q;
   logic [PRES_W-1:0] pres_sh_q, pres_act_q;
   logic [CNT_W-1:0] reload_q;
   logic             lvl, rise, fall;
   logic [7:0]       hi_byte, setup_byte;

   assign wr_stat  = bus_wr && (bus_addr == A_STAT);
   assign wr_setup = bus_wr && (bus_addr == A_SETUP);
   assign en_d     = wr_setup ? bus_wdata[7] : en_q;
   assign ch_st    = en_q & (|ch_evt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_st_q   <= 1'b0;
         ie_q       <= 1'b0;
         src_q      <= SRC_SYS;
         en_q       <= 1'b0;
         mode_q     <= MODE_WRAP;
         pres_sh_q  <= '0;
         pres_act_q <= '0;
         reload_q   <= '0;
         irq_q      <= 1'b0;
      end else begin
         en_q  <= en_d;
         irq_q <= done & ie_q & en_d;
         if (!en_d)                          cyc_st_q <= 1'b0;
         else if (done)                      cyc_st_q <= 1'b1;
         else if (wr_stat && bus_wdata[7])   cyc_st_q <= 1'b0;
         if (wr_stat) begin
            ie_q  <= bus_wdata[5];
            src_q <= clk_src_e'(bus_wdata[2:0]);
         end
         if (wr_setup) begin
            mode_q    <= cnt_mode_e'(bus_wdata[6]);
            pres_sh_q <= bus_wdata[PRES_W-1:0];
         end
         if (wr_setup && !en_q)  pres_act_q <= bus_wdata[PRES_W-1:0];
         else if (done)          pres_act_q <= pres_sh_q;
         if (bus_wr && bus_addr == A_RLDH) reload_q[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
         if (bus_wr && bus_addr == A_RLDL) reload_q[7:0]       <= bus_wdata;
      end
   end

   mtc_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(tmr_in),
      .level_o(lvl), .rise_o(rise), .fall_o(fall));

   mtc_tick #(.PRES_W(PRES_W)) u_tick (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en_q), .src_i(src_q),
      .sclk_en_i(sclk_en), .level_i(lvl), .rise_i(rise), .fall_i(fall),
      .pres_i(pres_act_q), .tick_o(tick));

   mtc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en_q), .mode_i(mode_q),
      .tick_i(tick), .reload_i(reload_q), .cnt_o(count), .done_o(done));

   always_comb begin
      hi_byte               = '0;
      hi_byte[HI_W-1:0]     = reload_q[CNT_W-1:8];
      setup_byte            = '0;
      setup_byte[7]         = en_q;
      setup_byte[6]         = mode_q;
      setup_byte[PRES_W-1:0] = pres_sh_q;
      unique case (bus_addr)
         A_STAT:  bus_rdata = {cyc_st_q, ch_st, ie_q, 2'b00, src_q};
         A_SETUP: bus_rdata = setup_byte;
         A_RLDH:  bus_rdata = hi_byte;
         default: bus_rdata = reload_q[7:0];
      endcase
   end

   assign cnt_irq = irq_q;

   AST_STAT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !cyc_st_q)
      else $error("cycle status set while disabled"); // R10
   AST_IRQ_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_irq |-> cyc_st_q)
      else $error("interrupt without cycle status"); // R12
   AST_PRES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !done) |=> $stable(pres_act_q))
      else $error("active prescale changed mid-cycle"); // R9
endmodule

// File: tb/mtc_ctrl_test.sv
module mtc_ctrl_test;
   logic clk = 1'b0, rst_n = 1'b0, sclk_en = 1'b1, tmr_in = 1'b0, bus_wr = 1'b0;
   logic [3:0]  ch_evt = '0;
   logic [1:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0, bus_rdata, rv;
   logic [15:0] count;
   logic        cnt_irq;
   int tests = 0, fails = 0, irq_n = 0;

   always #5 clk = ~clk;

   mtc_ctrl uut (.clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .tmr_in(tmr_in),
      .ch_evt(ch_evt), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .count(count), .cnt_irq(cnt_irq));

   always @(negedge clk) if (cnt_irq) irq_n++;

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         tmr_in = 1'b1; wait_cyc(3);
         tmr_in = 1'b0; wait_cyc(3);
      end
   endtask

   function automatic int exp_count(input bit updn, input int r, input int n);
      int p;
      if (!updn) return (n <= r) ? n : ((n - r - 1) % r) + 1;
      p = n % (2 * r);
      return (p <= r) ? p : 2 * r - p;
   endfunction

   function automatic int exp_dones(input bit updn, input int r, input int n);
      if (updn) return n / (2 * r);
      return (n >= r + 1) ? 1 + (n - r - 1) / r : 0;
   endfunction

   initial begin
      #(10 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int seed, r, p, c, n;
      bit md;
      seed = $urandom(32'h1234);
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      // R1 reset state
      rd(0, rv); chk("R1 stat", rv, 8'h00);
      rd(1, rv); chk("R1 setup", rv, 8'h00);
      chk("R1 count", count, 0);
      chk("R1 irq", cnt_irq, 0);

      // R2 layout and reserved bits
      wr(0, 8'hFF); rd(0, rv); chk("R2 stat layout", rv, 8'h27);
      wr(1, 8'h47); rd(1, rv); chk("R2 setup readback", rv, 8'h47);
      wr(2, 8'hAB); rd(2, rv); chk("R2 reload hi", rv, 8'hAB);
      wr(3, 8'hCD); rd(3, rv); chk("R2 reload lo", rv, 8'hCD);

      // random runs on source 000: R3 R7 R8 R11 R12 R13
      for (int it = 0; it < 10; it++) begin
         r = 2 + int'($urandom % 39); p = int'($urandom % 4);
         c = 10 + int'($urandom % 391); md = 1'($urandom % 2);
         wr(1, 8'h00); wait_cyc(1);
         chk("R13 disabled count", count, 0);
         wr(3, 8'(r)); wr(2, 8'h00); wr(0, 8'h20);
         ch_evt = 4'($urandom);
         irq_n = 0;
         wr(1, {1'b1, md, 3'b000, 3'(p)});
         wait_cyc(c); #1;
         n = c >> p;
         chk(md ? "R8 updown count" : "R7 wrap count", count, exp_count(md, r, n));
         chk("R12 irq pulses", irq_n, exp_dones(md, r, n));
         rd(0, rv);
         chk("R10 status set", rv[7], (exp_dones(md, r, n) > 0) ? 1 : 0);
         chk("R11 channel or", rv[6], (ch_evt != 0) ? 1 : 0);
      end

      // R9 shadowed prescaler, R10 W1C and disable, R12 with enable off
      wr(1, 8'h00); wr(3, 8'd5); wr(2, 8'h00); wr(0, 8'h00);
      ch_evt = 4'hF;
      wr(1, 8'h80);
      wait_cyc(2); chk("R3 prescale 0", count, 2);
      wr(1, 8'h82); chk("R9 old divider kept", count, 3);
      rd(1, rv); chk("R9 readback", rv, 8'h82);
      wait_cyc(3); chk("R7 wrap to 1", count, 1);
      chk("R12 no irq when disabled", cnt_irq, 0);
      rd(0, rv); chk("R10 set on done", rv[7], 1);
      wait_cyc(3); chk("R9 new divider hold", count, 1);
      wait_cyc(1); chk("R9 new divider step", count, 2);
      wr(0, 8'h80); rd(0, rv); chk("R10 w1c", rv[7], 0);
      wait_cyc(15); rd(0, rv); chk("R10 set again", rv[7], 1);
      chk("R7 second wrap", count, 1);
      wr(1, 8'h00); rd(0, rv);
      chk("R10 cleared by disable", rv[7], 0);
      chk("R11 zero when disabled", rv[6], 0);
      ch_evt = 4'h0;

      // R4 gated sources
      tmr_in = 1'b0;
      wr(3, 8'hE8); wr(2, 8'h03); wr(0, 8'h02); wr(1, 8'h80);
      wait_cyc(20); chk("R4 gate high blocks", count, 0);
      tmr_in = 1'b1;
      wait_cyc(22); chk("R4 gate high counts", count, 20);
      wr(0, 8'h03); chk("R4 switch edge", count, 21);
      wait_cyc(10); chk("R4 gate low blocks", count, 21);
      tmr_in = 1'b0;
      wait_cyc(12); chk("R4 gate low counts", count, 31);

      // R3 sclk_en qualifies the system source
      wr(0, 8'h00); chk("R3 tick on write edge", count, 32);
      sclk_en = 1'b0;
      wait_cyc(10); chk("R3 sclk_en low holds", count, 32);
      sclk_en = 1'b1;
      wait_cyc(5); chk("R3 sclk_en resumes", count, 37);

      // R5 edge sources bypass prescaler
      wr(1, 8'h00); wr(0, 8'h04); wr(1, 8'h83);
      pulses(5); wait_cyc(4); chk("R5 rising edges", count, 5);
      wr(0, 8'h05);
      pulses(5); wait_cyc(4); chk("R5 falling edges", count, 10);

      // R6 reserved source
      wr(0, 8'h06);
      pulses(3); wait_cyc(4); chk("R6 reserved holds", count, 10);
      rd(1, rv); chk("R6 setup unchanged", rv, 8'h83);
      rd(0, rv); chk("R6 stat value", rv, 8'h06);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule